// File: doc/BRIEF.md
# USB IN Endpoint Control and Handshake Sequencer

This block holds the control and status byte of a single USB device IN endpoint and runs the handshake sequencing behind it. Firmware reaches it through a byte-wide register port. Firmware loads the endpoint FIFO, counted here one byte per `fifo_wr` strobe. It then marks the packet ready, or lets the block mark it ready once the byte count reaches the maximum packet size. The serial interface engine reports IN tokens, received ACKs and handshake timeouts. For each token it receives a registered answer: data, NAK or STALL, together with the DATA0/DATA1 identifier to use.

In bulk operation a packet stays armed until the host acknowledges it. A timeout leaves the packet, its byte count and the data toggle untouched, so the next IN token resends the same packet with the same identifier. In interrupt/rate-feedback mode a packet counts as delivered as soon as it has gone out, and the toggle advances on every transmission. A flush command empties the FIFO through a one-cycle strobe and discards the armed packet.

Top module: `in_ep_ctrl`

## Requirements
- R1: After reset the register reads 0x00, `resp_code` is 0 and `byte_cnt` is 0. The stall (bit 2), interrupt-mode (bit 4) and auto-arm (bit 7) bits read back as last written.
- R2: Bit 1 always reads 0, and so does the toggle-reset bit 3; writing 1 to either leaves the value of bit 1 unchanged.
- R3: Writing a byte with bit 0 set arms the packet (bit 0 reads 1). Writing bit 0 as 0 never clears it.
- R4: An IN token that arrives with the packet armed and stall clear gives `resp_code` 1 (data) in the next cycle, with `resp_pid` set to the current toggle (0 = DATA0, 1 = DATA1). `resp_code` is 0 in every cycle that follows no token.
- R5: An IN token that arrives with the packet not armed and stall clear gives `resp_code` 2 (NAK).
- R6: While stall is set, an IN token gives `resp_code` 3 (STALL) and leaves the armed state unchanged.
- R7: In bulk mode an ACK that follows a data response clears bit 0, bit 5 and `byte_cnt`, and flips the toggle.
- R8: A timeout after a data response keeps bits 0 and 5 and `byte_cnt`; the next token resends data with the same `resp_pid`.
- R9: Each `fifo_wr` adds one to `byte_cnt`, and the first one sets the FIFO-not-empty flag (bit 5).
- R10: Writing bit 6 pulses `flush_o` for one cycle in the next cycle, while bit 6 reads 1. In the cycle after that, bits 0, 5 and 6 and `byte_cnt` are all 0.
- R11: Writing bit 3 as 1 resets the toggle, so the next data response carries `resp_pid` 0.
- R12: With bit 7 set, the FIFO write that brings `byte_cnt` up to `max_pkt` arms the packet and no earlier write does. With bit 7 clear, FIFO writes never arm it.
- R13: With bit 4 set, a data response clears bits 0 and 5 at once and flips the toggle without any ACK.
- R14: An ACK that arrives while no data response is outstanding has no effect on the armed bit or on the toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| fifo_wr | input | 1 | One byte written into the endpoint FIFO |
| max_pkt | input | CNT_W | Maximum packet size used by auto-arm |
| tok_in | input | 1 | IN token received |
| ack_rx | input | 1 | ACK received from host |
| hs_timeout | input | 1 | No handshake arrived after a data packet |
| resp_code | output | 2 | 0 none, 1 data, 2 NAK, 3 STALL |
| resp_pid | output | 1 | 0 DATA0, 1 DATA1 for a data response |
| flush_o | output | 1 | FIFO flush strobe |
| byte_cnt | output | CNT_W | Bytes written into the FIFO for the current packet |

## Verification
The properties assume that the engine reports an ACK or a timeout only after a data response, never both in one cycle and never in the same cycle as a token. They also assume that register writes do not coincide with handshake events, and that `max_pkt` is nonzero and held steady while a packet is filling. The bench drives each event from its own task, one event per cycle, so these assumptions hold. It sweeps `max_pkt` from 1 to 8 and runs a bulk sequence in which every third packet loses its ACK.

// File: rtl/in_ep_pkg.sv
package in_ep_pkg;
  typedef enum logic [1:0] {
    RSP_NONE  = 2'd0,
    RSP_DATA  = 2'd1,
    RSP_NAK   = 2'd2,
    RSP_STALL = 2'd3
  } rsp_e;

  localparam int B_ARM   = 0;
  localparam int B_STALL = 2;
  localparam int B_TGRST = 3;
  localparam int B_IMODE = 4;
  localparam int B_NEMP  = 5;
  localparam int B_FLUSH = 6;
  localparam int B_AUTO  = 7;
endpackage

// File: rtl/in_ep_fill.sv
module in_ep_fill #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic             clr,
  input  logic [CNT_W-1:0] max_pkt,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nx;
  logic             at_top;

  always_comb begin
    at_top = (cnt_q == CNT_TOP);
    cnt_nx = cnt_q + 1'b1;
    full_o = wr && !clr && !at_top && (cnt_nx == max_pkt);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (wr && !at_top) cnt_q <= cnt_nx;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/in_ep_seq.sv
module in_ep_seq
  import in_ep_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tok_in,
  input  logic       ack_rx,
  input  logic       hs_timeout,
  input  logic       flush,
  input  logic       tog_init,
  input  logic       stall,
  input  logic       armed,
  input  logic       imode,
  output logic [1:0] rsp_o,
  output logic       pid_o,
  output logic       done_o
);
  rsp_e rsp_q;
  logic pid_q;
  logic tog_q;
  logic wait_q;
  logic send;

  always_comb begin
    send   = tok_in && !stall && armed;
    done_o = (send && imode) || (ack_rx && wait_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_q  <= RSP_NONE;
      pid_q  <= 1'b0;
      tog_q  <= 1'b0;
      wait_q <= 1'b0;
    end else begin
      if (!tok_in)    rsp_q <= RSP_NONE;
      else if (stall) rsp_q <= RSP_STALL;
      else if (armed) rsp_q <= RSP_DATA;
      else            rsp_q <= RSP_NAK;

      if (send) pid_q <= tog_q;

      if (flush)                                 wait_q <= 1'b0;
      else if (send && !imode)                   wait_q <= 1'b1;
      else if (wait_q && (ack_rx || hs_timeout)) wait_q <= 1'b0;

      if (tog_init)    tog_q <= 1'b0;
      else if (done_o) tog_q <= ~tog_q;
    end
  end

  assign rsp_o = rsp_q;
  assign pid_o = pid_q;
endmodule

// File: rtl/in_ep_ctrl.sv
module in_ep_ctrl
  import in_ep_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             fifo_wr,
  input  logic [CNT_W-1:0] max_pkt,
  input  logic             tok_in,
  input  logic             ack_rx,
  input  logic             hs_timeout,
  output logic [1:0]       resp_code,
  output logic             resp_pid,
  output logic             flush_o,
  output logic [CNT_W-1:0] byte_cnt
);
  logic arm_q, stall_q, imode_q, nemp_q, flush_q, auto_q;
  logic done, full, tog_init, set_arm, drop;

  always_comb begin
    tog_init = reg_wr && reg_wdata[B_TGRST];
    set_arm  = (reg_wr && reg_wdata[B_ARM]) || (auto_q && full);
    drop     = flush_q || done;
  end

  in_ep_fill #(.CNT_W(CNT_W)) fill_i (
    .clk     (clk),
    .rst     (rst),
    .wr      (fifo_wr),
    .clr     (drop),
    .max_pkt (max_pkt),
    .cnt_o   (byte_cnt),
    .full_o  (full)
  );

  in_ep_seq seq_i (
    .clk        (clk),
    .rst        (rst),
    .tok_in     (tok_in),
    .ack_rx     (ack_rx),
    .hs_timeout (hs_timeout),
    .flush      (flush_q),
    .tog_init   (tog_init),
    .stall      (stall_q),
    .armed      (arm_q),
    .imode      (imode_q),
    .rsp_o      (resp_code),
    .pid_o      (resp_pid),
    .done_o     (done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q   <= 1'b0;
      stall_q <= 1'b0;
      imode_q <= 1'b0;
      nemp_q  <= 1'b0;
      flush_q <= 1'b0;
      auto_q  <= 1'b0;
    end else begin
      if (reg_wr) begin
        stall_q <= reg_wdata[B_STALL];
        imode_q <= reg_wdata[B_IMODE];
        auto_q  <= reg_wdata[B_AUTO];
      end
      flush_q <= reg_wr && reg_wdata[B_FLUSH];

      if (drop)         arm_q <= 1'b0;
      else if (set_arm) arm_q <= 1'b1;

      if (drop)         nemp_q <= 1'b0;
      else if (fifo_wr) nemp_q <= 1'b1;
    end
  end

  assign flush_o   = flush_q;
  assign reg_rdata = {auto_q, flush_q, nemp_q, imode_q, 1'b0, stall_q, 1'b0, arm_q};
endmodule

// File: rtl/in_ep_ctrl_chk.sv
module in_ep_ctrl_chk #(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_wr,
  input logic [7:0]       reg_wdata,
  input logic [7:0]       reg_rdata,
  input logic             fifo_wr,
  input logic [CNT_W-1:0] max_pkt,
  input logic             tok_in,
  input logic             ack_rx,
  input logic             hs_timeout,
  input logic [1:0]       resp_code,
  input logic             flush_o,
  input logic [CNT_W-1:0] byte_cnt,
  input logic             wait_q,
  input logic             tog_q
);
  localparam logic [CNT_W-1:0] TOP = '1;

  // R4
  data_resp_chk: assert property (@(posedge clk) disable iff (rst)
    tok_in && !reg_rdata[2] && reg_rdata[0] |=> resp_code == 2'd1);

  // R5
  nak_resp_chk: assert property (@(posedge clk) disable iff (rst)
    tok_in && !reg_rdata[2] && !reg_rdata[0] |=> resp_code == 2'd2);

  // R6
  stall_resp_chk: assert property (@(posedge clk) disable iff (rst)
    tok_in && reg_rdata[2] |=> resp_code == 2'd3);

  // R7
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ack_rx && wait_q && !reg_wr |=> !reg_rdata[0] && !reg_rdata[5] && byte_cnt == '0);

  // R7
  ack_flip_chk: assert property (@(posedge clk) disable iff (rst)
    ack_rx && wait_q && !(reg_wr && reg_wdata[3]) |=> tog_q != $past(tog_q));

  // R8
  timeout_keep_chk: assert property (@(posedge clk) disable iff (rst)
    hs_timeout && wait_q && reg_rdata[0] && !ack_rx && !flush_o |=> reg_rdata[0]);

  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    flush_o |=> !reg_rdata[0] && !reg_rdata[5] && byte_cnt == '0);

  // R12
  auto_arm_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_wr && reg_rdata[7] && !flush_o && !ack_rx && !tok_in &&
    byte_cnt != TOP && (byte_cnt + 1'b1) == max_pkt |=> reg_rdata[0]);

  // R14
  stray_ack_chk: assert property (@(posedge clk) disable iff (rst)
    ack_rx && !wait_q && !tok_in && !flush_o && !reg_wr && reg_rdata[0] |=> reg_rdata[0]);
endmodule

bind in_ep_ctrl in_ep_ctrl_chk #(.CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .reg_wr     (reg_wr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .fifo_wr    (fifo_wr),
  .max_pkt    (max_pkt),
  .tok_in     (tok_in),
  .ack_rx     (ack_rx),
  .hs_timeout (hs_timeout),
  .resp_code  (resp_code),
  .flush_o    (flush_o),
  .byte_cnt   (byte_cnt),
  .wait_q     (seq_i.wait_q),
  .tog_q      (seq_i.tog_q)
);

// File: tb/in_ep_ctrl_tb_top.sv
module in_ep_ctrl_tb_top;
  localparam int CNT_W = 7;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             reg_wr = 1'b0;
  logic [7:0]       reg_wdata = 8'h00;
  logic [7:0]       reg_rdata;
  logic             fifo_wr = 1'b0;
  logic [CNT_W-1:0] max_pkt = 7'd4;
  logic             tok_in = 1'b0;
  logic             ack_rx = 1'b0;
  logic             hs_timeout = 1'b0;
  logic [1:0]       resp_code;
  logic             resp_pid;
  logic             flush_o;
  logic [CNT_W-1:0] byte_cnt;

  int total = 0;
  int bad = 0;
  bit exp_tog = 1'b0;

  always #4 clk = ~clk;

  in_ep_ctrl #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fifo_wr(fifo_wr), .max_pkt(max_pkt), .tok_in(tok_in), .ack_rx(ack_rx),
    .hs_timeout(hs_timeout), .resp_code(resp_code), .resp_pid(resp_pid),
    .flush_o(flush_o), .byte_cnt(byte_cnt)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [7:0] v);
    reg_wr = 1'b1; reg_wdata = v;
    tick();
    reg_wr = 1'b0; reg_wdata = 8'h00;
  endtask

  task automatic wbytes(input int n);
    for (int i = 0; i < n; i++) begin
      fifo_wr = 1'b1;
      tick();
      fifo_wr = 1'b0;
    end
  endtask

  task automatic token();
    tok_in = 1'b1;
    tick();
    tok_in = 1'b0;
  endtask

  task automatic ack();
    ack_rx = 1'b1;
    tick();
    ack_rx = 1'b0;
  endtask

  task automatic tmo();
    hs_timeout = 1'b1;
    tick();
    hs_timeout = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    check("R1 rdata", reg_rdata, 8'h00);
    check("R1 resp", resp_code, 0);
    check("R1 cnt", byte_cnt, 0);

    // R1 stored bits, R2 reserved bit ignored
    wreg(8'b1001_0110);
    check("R1 stored", reg_rdata, 8'h94);
    check("R2 bit1", reg_rdata[1], 0);
    wreg(8'h00);
    check("R1 cleared", reg_rdata, 8'h00);

    // R3 arm by software, write 0 no effect
    wreg(8'h01);
    check("R3 arm", reg_rdata[0], 1);
    wreg(8'h00);
    check("R3 keep", reg_rdata[0], 1);

    // R9 byte count and not-empty flag
    wbytes(1);
    check("R9 nemp", reg_rdata[5], 1);
    wbytes(4);
    check("R9 cnt", byte_cnt, 5);

    // R4 data response
    token();
    check("R4 code", resp_code, 1);
    check("R4 pid", resp_pid, exp_tog);
    tick();
    check("R4 idle", resp_code, 0);

    // R8 timeout keeps packet
    tmo();
    check("R8 arm", reg_rdata[0], 1);
    check("R8 nemp", reg_rdata[5], 1);
    check("R8 cnt", byte_cnt, 5);
    token();
    check("R8 resend", resp_code, 1);
    check("R8 pid", resp_pid, exp_tog);

    // R7 ack clears
    ack();
    exp_tog = ~exp_tog;
    check("R7 rdata", reg_rdata, 8'h00);
    check("R7 cnt", byte_cnt, 0);

    // R5 NAK
    token();
    check("R5 nak", resp_code, 2);

    // R14 stray ack
    wreg(8'h01);
    ack();
    check("R14 arm", reg_rdata[0], 1);
    token();
    check("R14 pid", resp_pid, exp_tog);
    ack();
    exp_tog = ~exp_tog;

    // R11 toggle reset
    wreg(8'h01);
    token();
    check("R11 pre pid", resp_pid, exp_tog);
    ack();
    exp_tog = ~exp_tog;
    wreg(8'h09);
    check("R2 bit3", reg_rdata[3], 0);
    exp_tog = 1'b0;
    token();
    check("R11 pid", resp_pid, 0);
    ack();
    exp_tog = ~exp_tog;

    // R6 stall
    wreg(8'h04);
    token();
    check("R6 stall idle", resp_code, 3);
    wreg(8'h05);
    token();
    check("R6 stall armed", resp_code, 3);
    check("R6 keep", reg_rdata[0], 1);
    wreg(8'h00);
    token();
    check("R6 after", resp_code, 1);
    check("R6 pid", resp_pid, exp_tog);
    ack();
    exp_tog = ~exp_tog;

    // R10 flush
    wbytes(3);
    wreg(8'h01);
    wreg(8'h40);
    check("R10 strobe", flush_o, 1);
    check("R10 bit6", reg_rdata[6], 1);
    tick();
    check("R10 strobe off", flush_o, 0);
    check("R10 rdata", reg_rdata, 8'h00);
    check("R10 cnt", byte_cnt, 0);

    // R12 auto-arm sweep
    for (int m = 1; m <= 8; m++) begin
      max_pkt = m[CNT_W-1:0];
      wreg(8'h80);
      for (int b = 1; b <= m; b++) begin
        wbytes(1);
        check("R12 arm", reg_rdata[0], (b == m) ? 1 : 0);
        check("R12 cnt", byte_cnt, b);
      end
      token();
      check("R12 data", resp_code, 1);
      check("R12 pid", resp_pid, exp_tog);
      ack();
      exp_tog = ~exp_tog;
      check("R12 clear", reg_rdata[0], 0);
    end
    max_pkt = 7'd3;
    wreg(8'h00);
    wbytes(3);
    check("R12 off", reg_rdata[0], 0);
    wreg(8'h40);
    tick();

    // R13 interrupt mode
    for (int k = 0; k < 4; k++) begin
      wbytes(k + 1);
      wreg(8'h11);
      token();
      check("R13 data", resp_code, 1);
      check("R13 pid", resp_pid, exp_tog);
      exp_tog = ~exp_tog;
      check("R13 rdata", reg_rdata, 8'h10);
      check("R13 cnt", byte_cnt, 0);
    end
    token();
    check("R13 nak", resp_code, 2);

    // R7/R8 bulk sequence with lost handshakes
    wreg(8'h00);
    for (int i = 0; i < 12; i++) begin
      wbytes(1 + i % 4);
      wreg(8'h01);
      token();
      check("R7 data", resp_code, 1);
      check("R7 pid", resp_pid, exp_tog);
      if (i % 3 == 1) begin
        tmo();
        check("R8 held", reg_rdata[0], 1);
        check("R8 cnt held", byte_cnt, 1 + i % 4);
        token();
        check("R8 repid", resp_pid, exp_tog);
      end
      ack();
      exp_tog = ~exp_tog;
      check("R7 done", reg_rdata[0], 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule